// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder with Selectable Flush-to-Zero

This block adds or subtracts two 32-bit binary floating-point operands in the standard single-precision layout: a sign bit, an 8-bit biased exponent and a 23-bit fraction. It always rounds to nearest, with ties going to the even neighbour. There is no rounding-mode input. One mode input picks how tiny values are treated. In one setting, subnormal operands and subnormal results become signed zeros. In the other setting, gradual underflow is supported in full.

The block never reports an exception. Every exceptional event gets the quiet default answer:
- Overflow returns a correctly signed infinity.
- An invalid operation returns NaN.
- Any NaN on an input returns one fixed NaN word. The payload and sign of the input NaN do not matter. Signalling NaN encodings are treated as quiet NaNs.

An operation is issued by raising `inValid` for one cycle, together with the operands, the subtract control and the mode bit. The result appears on the next cycle, with `outValid` high for that one cycle. The result register keeps its value until the next issued operation.

Top module: `fpAddUnit`

## Requirements
- R1: For finite, non-NaN operands, `result` is the exact sum rounded to nearest, ties to even. A sum exactly halfway between two neighbours rounds to the one whose fraction LSB (bit 0) is 0.
- R2: When `subtract` is 1, the result is `opA` minus `opB`. This is computed as `opA` plus `opB` with bit 31 (the sign) inverted.
- R3: When either operand is a NaN, `result` is exactly 32'h7FFFFFFF. A NaN is an operand with bits 30:23 all ones and bits 22:0 not zero. This holds for signalling encodings (bit 22 clear) and quiet encodings alike.
- R4: Infinity is an operand with bits 30:23 all ones and bits 22:0 zero.
  - Infinity plus a finite value returns that infinity.
  - Two infinities with equal effective signs return that infinity.
  - Two infinities with opposite effective signs return 32'h7FFFFFFF.
- R5: A rounded result whose magnitude reaches 2^128 returns infinity with the sign of the sum: exponent field 8'hFF and fraction 0.
- R6: With `ftzMode` = 0, subnormal operands (exponent field 0, fraction not zero) count as fraction × 2^-149. Results below 2^-126 are delivered as subnormals without flushing.
- R7: With `ftzMode` = 1, a subnormal operand is treated as a zero that keeps its own sign.
- R8: With `ftzMode` = 1, a result that would be subnormal after rounding is delivered as a zero carrying the sign of the sum.
- R9: An exact zero sum is +0. The one exception is when both addends, after the subtract sign flip, are negative zeros: the result is then -0.
- R10: After reset, `outValid` is 0 and `result` is 0. `outValid` is 1 in exactly the cycle after each cycle with `inValid` = 1. `result` changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Issue strobe for one operation |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| subtract | input | 1 | 1 computes opA minus opB |
| ftzMode | input | 1 | 1 flushes subnormal inputs and results to zero |
| outValid | output | 1 | High for one cycle when result is new |
| result | output | 32 | Rounded sum or difference |

## Verification
The assertions sample the operands in the cycle in which `inValid` is high and compare them with `result` one cycle later. They therefore assume that `inValid`, `ftzMode` and the operands are known values at every rising edge after reset. The bench meets this in two ways:
- It drives every input on the falling edge.
- It holds `inValid` low with defined operands between operations.

The random operands are drawn from classes (specials, subnormals, values near the largest finite value, and equal exponents for cancellation). This keeps the tie, carry and flush paths that the properties cover well populated.

// File: rtl/fpAddPkg.sv
package fpAddPkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  // hidden bit + fraction + guard, round, sticky
  localparam int EXT_W  = MAN_W + 4;
  localparam int EXPI_W = EXP_W + 2;
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam logic [EXP_W-1:0]  EXP_ONES  = {EXP_W{1'b1}};
  localparam logic [WORD_W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b1}}};

  typedef struct packed {
    logic capture;   // load the result register
    logic validSet;  // mark the next cycle valid
  } addStrobe_t;
endpackage

// File: rtl/fpAddCtrl.sv
module fpAddCtrl
  import fpAddPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output addStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.capture  = inValid;
    strobe.validSet = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.validSet;
  end
endmodule

// File: rtl/fpAddPath.sv
module fpAddPath
  import fpAddPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  addStrobe_t        strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subtract,
  input  logic              ftzMode,
  output logic [WORD_W-1:0] result
);
  logic              signA, signB;
  logic [EXP_W-1:0]  expA, expB;
  logic [MAN_W-1:0]  manA, manB;
  logic              nanIn, infA, infB;
  logic              swap, bigSign, smallSign, effSub;
  logic [EXP_W-1:0]  bigExp, smallExp, bigEff, smallEff, expDiff;
  logic [MAN_W-1:0]  bigMan, smallMan;
  logic [EXT_W-1:0]  bigExt, smallExt, aligned, lostMask;
  logic [EXT_W:0]    sumRaw;
  logic [EXT_W-1:0]  normMan;
  logic [LZ_W-1:0]   lzCount;
  logic [EXPI_W-1:0] expWork, shiftLim, shiftAmt, expNorm, expField;
  logic              roundUp;
  logic [EXPI_W+MAN_W-1:0] packedRes, roundedRes;
  logic [WORD_W-1:0] nextRes;

  always_comb begin
    signA = opA[WORD_W-1];
    signB = opB[WORD_W-1] ^ subtract;
    expA  = opA[WORD_W-2:MAN_W];
    expB  = opB[WORD_W-2:MAN_W];
    nanIn = (expA == EXP_ONES && opA[MAN_W-1:0] != '0) ||
            (expB == EXP_ONES && opB[MAN_W-1:0] != '0);
    infA  = (expA == EXP_ONES) && !nanIn;
    infB  = (expB == EXP_ONES) && !nanIn;
    manA  = (ftzMode && expA == '0) ? '0 : opA[MAN_W-1:0];
    manB  = (ftzMode && expB == '0) ? '0 : opB[MAN_W-1:0];

    // order by magnitude so the big operand fixes the sign and exponent
    swap      = {expB, manB} > {expA, manA};
    bigSign   = swap ? signB : signA;
    smallSign = swap ? signA : signB;
    bigExp    = swap ? expB  : expA;
    smallExp  = swap ? expA  : expB;
    bigMan    = swap ? manB  : manA;
    smallMan  = swap ? manA  : manB;
    effSub    = bigSign ^ smallSign;

    bigEff   = (bigExp == '0)   ? EXP_W'(1) : bigExp;
    smallEff = (smallExp == '0) ? EXP_W'(1) : smallExp;
    expDiff  = bigEff - smallEff;
    bigExt   = {bigExp != '0, bigMan, 3'b000};
    smallExt = {smallExp != '0, smallMan, 3'b000};

    // alignment keeps guard and round bits, collapses the rest into sticky
    lostMask = ~({EXT_W{1'b1}} << expDiff);
    aligned  = (smallExt >> expDiff);
    aligned[0] = aligned[0] | (|(smallExt & lostMask));

    sumRaw = effSub ? ({1'b0, bigExt} - {1'b0, aligned})
                    : ({1'b0, bigExt} + {1'b0, aligned});

    lzCount = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (sumRaw[i]) lzCount = LZ_W'(EXT_W - 1 - i);

    expWork  = EXPI_W'(bigEff);
    shiftLim = expWork - EXPI_W'(1);
    shiftAmt = (EXPI_W'(lzCount) < shiftLim) ? EXPI_W'(lzCount) : shiftLim;
    if (sumRaw[EXT_W]) begin
      normMan    = sumRaw[EXT_W:1];
      normMan[0] = sumRaw[1] | sumRaw[0];
      expNorm    = expWork + EXPI_W'(1);
    end else begin
      normMan = sumRaw[EXT_W-1:0] << shiftAmt;
      expNorm = expWork - shiftAmt;
    end
    expField = normMan[EXT_W-1] ? expNorm : '0;

    // round to nearest even; a mantissa carry ripples into the exponent
    roundUp    = normMan[2] & (normMan[1] | normMan[0] | normMan[3]);
    packedRes  = {expField, normMan[EXT_W-2:3]};
    roundedRes = packedRes + (EXPI_W+MAN_W)'(roundUp);

    if (nanIn || (infA && infB && effSub))
      nextRes = CANON_NAN;
    else if (infA)
      nextRes = {signA, EXP_ONES, {MAN_W{1'b0}}};
    else if (infB)
      nextRes = {signB, EXP_ONES, {MAN_W{1'b0}}};
    else if (sumRaw == '0)
      nextRes = {bigSign & smallSign, {(WORD_W-1){1'b0}}};
    else if (roundedRes[EXPI_W+MAN_W-1:MAN_W] >= EXPI_W'(EXP_ONES))
      nextRes = {bigSign, EXP_ONES, {MAN_W{1'b0}}};
    else if (ftzMode && roundedRes[EXPI_W+MAN_W-1:MAN_W] == '0)
      nextRes = {bigSign, {(WORD_W-1){1'b0}}};
    else
      nextRes = {bigSign, roundedRes[EXP_W+MAN_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)               result <= '0;
    else if (strobe.capture) result <= nextRes;
  end
endmodule

// File: rtl/fpAddUnit.sv
module fpAddUnit
  import fpAddPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        subtract,
  input  logic        ftzMode,
  output logic        outValid,
  output logic [31:0] result
);
  addStrobe_t strobe;

  fpAddCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  fpAddPath u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .subtract(subtract), .ftzMode(ftzMode),
    .result(result)
  );
endmodule

// File: rtl/fpAddChecks.sv
module fpAddChecks (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic        subtract,
  input logic        ftzMode,
  input logic        outValid,
  input logic [31:0] result
);
  logic aNaN, bNaN, aInf, bInf;
  assign aNaN = (opA[30:23] == 8'hFF) && (opA[22:0] != '0);
  assign bNaN = (opB[30:23] == 8'hFF) && (opB[22:0] != '0);
  assign aInf = (opA[30:23] == 8'hFF) && (opA[22:0] == '0);
  assign bInf = (opB[30:23] == 8'hFF) && (opB[22:0] == '0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result)); // R10
  AST_NAN_CANONICAL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (aNaN || bNaN)) |=> result == 32'h7FFFFFFF); // R3
  AST_INF_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && aInf && !bNaN && !bInf) |=> result == {$past(opA[31]), 8'hFF, 23'h0}); // R4
  AST_FTZ_NO_TINY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ftzMode) |=> !(result[30:23] == 8'h00 && result[22:0] != '0)); // R8
  AST_TOP_EXP_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && result[30:23] == 8'hFF) |-> (result[22:0] == '0 || result == 32'h7FFFFFFF)); // R5
endmodule

bind fpAddUnit fpAddChecks u_chk (.*);

// File: tb/fpAddUnit_test.sv
module fpAddUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        subtract = 1'b0, ftzMode = 1'b0;
  logic        outValid;
  logic [31:0] result;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fpAddUnit uut (.*);

  // {a, b, subtract, ftz, expected}
  localparam int NVEC = 22;
  localparam logic [97:0] VEC [NVEC] = '{
    {32'h3F800000, 32'h3F800000, 1'b0, 1'b0, 32'h40000000}, // R1 1+1
    {32'h3F800000, 32'h3F800000, 1'b1, 1'b0, 32'h00000000}, // R2 R9 1-1
    {32'h40400000, 32'h3F800000, 1'b1, 1'b0, 32'h40000000}, // R2 3-1
    {32'h7FC00000, 32'h3F800000, 1'b0, 1'b0, 32'h7FFFFFFF}, // R3 quiet
    {32'h7F800001, 32'hFFC12345, 1'b0, 1'b0, 32'h7FFFFFFF}, // R3 signalling
    {32'h7F800000, 32'hFF800000, 1'b0, 1'b0, 32'h7FFFFFFF}, // R4 inf-inf
    {32'h7F800000, 32'hFF800000, 1'b1, 1'b0, 32'h7F800000}, // R4 inf--inf
    {32'hFF800000, 32'h3F800000, 1'b0, 1'b0, 32'hFF800000}, // R4 inf+finite
    {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 1'b0, 32'h7F800000}, // R5
    {32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 1'b0, 32'hFF800000}, // R5 negative
    {32'h00000001, 32'h00000001, 1'b0, 1'b0, 32'h00000002}, // R6
    {32'h00800000, 32'h00000001, 1'b1, 1'b0, 32'h007FFFFF}, // R6
    {32'h00800000, 32'h00000001, 1'b1, 1'b1, 32'h00800000}, // R7
    {32'h80000001, 32'h00000001, 1'b0, 1'b1, 32'h00000000}, // R7
    {32'h00800001, 32'h00800000, 1'b1, 1'b1, 32'h00000000}, // R8
    {32'h00800000, 32'h00800001, 1'b1, 1'b1, 32'h80000000}, // R8
    {32'h80000000, 32'h80000000, 1'b0, 1'b0, 32'h80000000}, // R9
    {32'h80000000, 32'h00000000, 1'b1, 1'b0, 32'h80000000}, // R9
    {32'h80000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000}, // R9
    {32'h3F800000, 32'h33800000, 1'b0, 1'b0, 32'h3F800000}, // R1 tie to even
    {32'h3F800001, 32'h33800000, 1'b0, 1'b0, 32'h3F800002}, // R1 tie up
    {32'h3F800001, 32'h3F800000, 1'b1, 1'b0, 32'h34000000}  // R1 cancellation
  };

  // exact model: both operands as integers in units of 2^-149
  function automatic logic [31:0] refAdd(logic [31:0] a, logic [31:0] b,
                                         logic sub, logic ftz);
    logic sa, sb, s, up;
    logic [7:0] ea, eb;
    logic [22:0] ma, mb;
    logic [299:0] va, vb, mag, one, rem, half, m;
    logic [31:0] res;
    int p, sh, e;
    sa = a[31]; sb = b[31] ^ sub;
    ea = a[30:23]; eb = b[30:23]; ma = a[22:0]; mb = b[22:0];
    if ((ea == 8'hFF && ma != 0) || (eb == 8'hFF && mb != 0)) return 32'h7FFFFFFF;
    if (ea == 8'hFF && eb == 8'hFF) return (sa == sb) ? {sa, 8'hFF, 23'h0} : 32'h7FFFFFFF;
    if (ea == 8'hFF) return {sa, 8'hFF, 23'h0};
    if (eb == 8'hFF) return {sb, 8'hFF, 23'h0};
    if (ftz && ea == 0) ma = 0;
    if (ftz && eb == 0) mb = 0;
    one = 1;
    va = (ea == 0) ? 300'(ma) : (300'({1'b1, ma}) << (ea - 1));
    vb = (eb == 0) ? 300'(mb) : (300'({1'b1, mb}) << (eb - 1));
    if (sa == sb) begin mag = va + vb; s = sa; end
    else if (va >= vb) begin mag = va - vb; s = sa; end
    else begin mag = vb - va; s = sb; end
    if (mag == 0) return {sa & sb, 31'h0};
    p = 0;
    for (int i = 0; i < 300; i++) if (mag[i]) p = i;
    if (p <= 23) res = {s, mag[30:0]};
    else begin
      sh = p - 23;
      m = mag >> sh;
      rem = mag & ((one << sh) - 1);
      half = one << (sh - 1);
      up = (rem > half) || (rem == half && m[0]);
      m = m + 300'(up);
      if (m[24]) begin m = m >> 1; sh = sh + 1; end
      e = sh + 1;
      if (e >= 255) return {s, 8'hFF, 23'h0};
      res = {s, e[7:0], m[22:0]};
    end
    if (ftz && res[30:23] == 0 && res[22:0] != 0) res = {s, 31'h0};
    return res;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic runOp(logic [31:0] a, logic [31:0] b, logic sub, logic ftz,
                       output logic [31:0] res, output logic vld);
    @(negedge clk);
    opA = a; opB = b; subtract = sub; ftzMode = ftz; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    res = result; vld = outValid;
  endtask

  function automatic logic [31:0] randOp(logic [31:0] other);
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 6)
      0: r[30:23] = 8'h00;                             // subnormal or zero
      1: r[30:23] = 8'hFE - 8'($urandom % 3);          // near the top
      2: r = ($urandom % 2) ? {r[31], 8'hFF, 23'h0} : {r[31], 31'h0};
      3: r[30:23] = other[30:23];                      // cancellation
      4: r[30:23] = other[30:23] - 8'($urandom % 30);  // partial overlap
      default: ;
    endcase
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] res, a, b;
    logic vld, sub, ftz;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset outValid", {31'h0, outValid}, 32'h0);
    check("R10 reset result", result, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i][97:66], VEC[i][65:34], VEC[i][33], VEC[i][32], res, vld);
      check($sformatf("vector %0d", i), res, VEC[i][31:0]);
    end

    // R10 valid pulse and hold
    runOp(32'h40000000, 32'h3F800000, 1'b0, 1'b0, res, vld);
    check("R10 outValid pulse", {31'h0, vld}, 32'h1);
    check("R1 2+1", res, 32'h40400000);
    opA = 32'h12345678; opB = 32'h7FC00000;
    @(negedge clk);
    check("R10 outValid drops", {31'h0, outValid}, 32'h0);
    check("R10 result held", result, 32'h40400000);
    repeat (3) @(negedge clk);
    check("R10 result still held", result, 32'h40400000);

    // R3 NaN on second operand with subtract
    runOp(32'h3F800000, 32'hFF800123, 1'b1, 1'b1, res, vld);
    check("R3 sNaN second operand", res, 32'h7FFFFFFF);

    // random operands against the exact model (R1 R2 R5 R6 R7 R8 R9)
    for (int n = 0; n < 3000; n++) begin
      a = randOp(32'h3F800000 ^ 32'($urandom % 2**28));
      b = randOp(a);
      sub = 1'($urandom);
      ftz = 1'($urandom);
      runOp(a, b, sub, ftz, res, vld);
      check($sformatf("R1 random %08h %08h sub=%0d ftz=%0d", a, b, sub, ftz),
            res, refAdd(a, b, sub, ftz));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule